// File: doc/BRIEF.md
# Framebuffer Scan-Out Address Generator

This block walks a linear framebuffer in memory and turns it into a stream of pixel colours for a fixed 640 by 480 true-colour display. Software programs a base address and a small control word through a two-word register window. After that, each frame-start pulse begins a new frame. Every pixel-advance strobe moves the scan on by one pixel and captures the colour word fetched for the pixel just left behind.

Each pixel is one 32-bit word in memory. A row occupies 1024 words, but only the first 640 of them are shown. Because the row stride is a power of two, the fetch byte address is assembled by concatenating the kept upper base bits, the row number, the column number and two zero bits. A rotate bit makes the whole frame scan backwards, from the last row and last column down to the origin, which turns the picture through 180 degrees. Sync timing, the memory bus protocol and clock-domain crossing belong to the surrounding logic.

Top module: `fb_scanout_top`

## Requirements
- R1: After reset, both registers read as zero, `fetchValid` and `frameDone` are low, and all three colour outputs are zero.
- R2: A write to register word 0 (`regAddr`=0) keeps only data bits 31:21. Reading word 0 returns those 11 bits in place, with bits 20:0 reading zero.
- R3: In register word 1 (`regAddr`=1), bit 0 is display enable and bit 1 is rotate. Reading it returns those two bits with every other bit zero. Writing zero clears both bits whatever they held before.
- R4: While `fetchValid` is high, `fetchAddr` equals {base[31:21], row[8:0], col[9:0], 2'b00}, with row below 480 and col below 640. Columns 640 to 1023 of a row are never addressed.
- R5: A `frameStart` while enabled with rotate clear begins at row 0, column 0. Each accepted step raises the column, and after column 639 the scan moves to column 0 of the next row.
- R6: A `frameStart` while enabled with rotate set begins at row 479, column 639. Each accepted step lowers the column, and after column 0 the scan moves to column 639 of the row above.
- R7: The rotate bit is sampled only at `frameStart`. Changing it mid-frame leaves the running frame's order unchanged.
- R8: The step that leaves the last pixel of a frame produces a one-cycle `frameDone` pulse. After it, `fetchValid` stays low until the next `frameStart`. A `frameStart` in mid-frame restarts at the first pixel.
- R9: One cycle after a step accepted while `fetchValid` is high, `pixR`, `pixG` and `pixB` show bits 23:16, 15:8 and 7:0 of `fetchData` as it was on that step. Bits 31:24 have no effect.
- R10: While enable is clear, `fetchValid` is low and the colour outputs read zero. Clearing enable abandons the running frame, so setting it again resumes nothing until a `frameStart`. A `frameStart` seen while disabled is ignored.
- R11: A `pixelStep` while `fetchValid` is low changes neither the colour outputs nor `frameDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | Register word select: 0 base, 1 control |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| frameStart | input | 1 | Begin a new frame |
| pixelStep | input | 1 | Advance to the next pixel |
| fetchValid | output | 1 | `fetchAddr` holds a pixel to be read |
| fetchAddr | output | 32 | Byte address of the current pixel word |
| fetchData | input | 32 | Memory word for `fetchAddr` |
| pixR | output | 8 | Red level |
| pixG | output | 8 | Green level |
| pixB | output | 8 | Blue level |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
The assertions assume that `fetchData` belongs to the address currently on `fetchAddr` within the same cycle. The bench meets this with a combinational memory model that derives each word from its address, including a non-zero top byte. They also assume the visible width and height fit in the column and row counter widths. The bench keeps to this by using a reduced 12 by 5 frame while leaving the 1024-word stride untouched. Pixel steps come randomly, on about seven cycles in ten, and the bench adds directed register writes at chosen points in a frame.

// File: rtl/fbscan_pkg.sv
package fbscan_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic load;  // move counters to the first pixel
    logic step;  // advance one pixel and capture colour
    logic rot;   // scan direction for this frame
  } scanStrobe_t;
endpackage

// File: rtl/fbscan_ctrl.sv
module fbscan_ctrl
  import fbscan_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [ADDR_W-1:0] regWrData,
  output logic [ADDR_W-1:0] regRdData,
  input  logic              frameStart,
  input  logic              pixelStep,
  input  logic              lastPix,
  output scanStrobe_t       strobe,
  output logic [BASE_W-1:0] baseHi,
  output logic              dispEn,
  output logic              fetchValid,
  output logic              frameDone
);
  localparam int LOW_W = ADDR_W - BASE_W;

  logic ctrlRot, active, rotFrame, doneQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      baseHi  <= '0;
      dispEn  <= 1'b0;
      ctrlRot <= 1'b0;
    end else if (regWrEn) begin
      if (regAddr) begin
        dispEn  <= regWrData[0];
        ctrlRot <= regWrData[1];
      end else begin
        baseHi <= regWrData[ADDR_W-1 -: BASE_W];
      end
    end
  end

  always_comb begin
    if (regAddr) regRdData = {{(ADDR_W-2){1'b0}}, ctrlRot, dispEn};
    else         regRdData = {baseHi, {LOW_W{1'b0}}};
  end

  always_comb begin
    strobe.load = frameStart & dispEn;
    strobe.step = pixelStep & active & dispEn & ~frameStart;
    strobe.rot  = strobe.load ? ctrlRot : rotFrame;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      rotFrame <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= strobe.step & lastPix;
      if (strobe.load) begin
        active   <= 1'b1;
        rotFrame <= ctrlRot;
      end else if (!dispEn || (strobe.step && lastPix)) begin
        active <= 1'b0;
      end
    end
  end

  assign fetchValid = active & dispEn;
  assign frameDone  = doneQ;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |=> !frameDone); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frameDone |-> !fetchValid); // R8
endmodule

// File: rtl/fbscan_datapath.sv
module fbscan_datapath
  import fbscan_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int V_VIS  = 480,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9,
  parameter int ADDR_W = 32,
  parameter int BASE_W = 11,
  parameter int BYTE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  scanStrobe_t       strobe,
  input  logic [BASE_W-1:0] baseHi,
  input  logic              dispEn,
  input  logic [31:0]       fetchData,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              lastPix,
  output logic [7:0]        pixR,
  output logic [7:0]        pixG,
  output logic [7:0]        pixB
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(H_VIS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(V_VIS - 1);
  localparam int CHANNELS = 3;

  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic [8*CHANNELS-1:0] pixWord;
  logic [7:0] chanOut [CHANNELS];

  assign lastPix = strobe.rot ? (row == '0 && col == '0)
                              : (row == ROW_LAST && col == COL_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row <= '0;
      col <= '0;
    end else if (strobe.load) begin
      row <= strobe.rot ? ROW_LAST : '0;
      col <= strobe.rot ? COL_LAST : '0;
    end else if (strobe.step && !lastPix) begin
      if (strobe.rot) begin
        if (col == '0) begin
          col <= COL_LAST;
          row <= row - 1'b1;
        end else begin
          col <= col - 1'b1;
        end
      end else begin
        if (col == COL_LAST) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           pixWord <= '0;
    else if (strobe.step) pixWord <= fetchData[8*CHANNELS-1:0];
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    assign chanOut[ch] = dispEn ? pixWord[8*ch +: 8] : 8'h00;
  end

  assign pixB = chanOut[0];
  assign pixG = chanOut[1];
  assign pixR = chanOut[2];

  assign fetchAddr = {baseHi, row, col, {BYTE_W{1'b0}}};

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_LAST); // R4
  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    row <= ROW_LAST); // R4
endmodule

// File: rtl/fb_scanout_top.sv
module fb_scanout_top
  import fbscan_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int V_VIS  = 480,
  parameter int COL_W  = 10,
  parameter int ROW_W  = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic        regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        frameStart,
  input  logic        pixelStep,
  output logic        fetchValid,
  output logic [31:0] fetchAddr,
  input  logic [31:0] fetchData,
  output logic [7:0]  pixR,
  output logic [7:0]  pixG,
  output logic [7:0]  pixB,
  output logic        frameDone
);
  localparam int ADDR_W = 32;
  localparam int BYTE_W = 2;
  localparam int BASE_W = ADDR_W - ROW_W - COL_W - BYTE_W;

  scanStrobe_t       strobe;
  logic [BASE_W-1:0] baseHi;
  logic              dispEn, lastPix;

  fbscan_ctrl #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameStart(frameStart),
    .pixelStep(pixelStep), .lastPix(lastPix), .strobe(strobe), .baseHi(baseHi),
    .dispEn(dispEn), .fetchValid(fetchValid), .frameDone(frameDone)
  );

  fbscan_datapath #(
    .H_VIS(H_VIS), .V_VIS(V_VIS), .COL_W(COL_W), .ROW_W(ROW_W),
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .BYTE_W(BYTE_W)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .baseHi(baseHi), .dispEn(dispEn),
    .fetchData(fetchData), .fetchAddr(fetchAddr), .lastPix(lastPix),
    .pixR(pixR), .pixG(pixG), .pixB(pixB)
  );

  AST_ADDR_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && pixelStep && !frameStart) |=>
      (frameDone || !fetchValid || fetchAddr != $past(fetchAddr))); // R5
endmodule

// File: tb/tb_fb_scanout_top.sv
`timescale 1ns/1ps
module tb_fb_scanout_top;
  localparam int H = 12;
  localparam int V = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        regWrEn, regAddr, frameStart, pixelStep;
  logic [31:0] regWrData, regRdData, fetchAddr, fetchData;
  logic        fetchValid, frameDone;
  logic [7:0]  pixR, pixG, pixB;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // model state
  logic [10:0] mBase;
  bit mEn, mRot, mActive, mRotF, mDone;
  int mRow, mCol;
  logic [23:0] mPix;

  always #4 clk = ~clk;

  fb_scanout_top #(.H_VIS(H), .V_VIS(V)) dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .frameStart(frameStart),
    .pixelStep(pixelStep), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchData(fetchData), .pixR(pixR), .pixG(pixG), .pixB(pixB),
    .frameDone(frameDone)
  );

  function automatic logic [31:0] memWord(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'hC3A50F17;
  endfunction

  assign fetchData = memWord(fetchAddr);

  function automatic logic [31:0] expAddr();
    return {mBase, 9'(mRow), 10'(mCol), 2'b00};
  endfunction

  task automatic check(input bit ok, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    bit ev;
    logic [23:0] ep;
    ev = mActive && mEn;
    ep = mEn ? mPix : 24'h0;
    check(fetchValid == ev, "R10 fetchValid", 32'(fetchValid), 32'(ev));
    if (ev)
      check(fetchAddr == expAddr(), mRotF ? "R4/R6 fetchAddr" : "R4/R5 fetchAddr",
            fetchAddr, expAddr());
    check({pixR, pixG, pixB} == ep, "R9 rgb", 32'({pixR, pixG, pixB}), 32'(ep));
    check(frameDone == mDone, "R8 frameDone", 32'(frameDone), 32'(mDone));
  endtask

  // One clock: drive at posedge+2, evaluate model, check after next edge
  task automatic cyc(input bit fs, input bit ps, input bit we, input bit wa,
                     input logic [31:0] wd);
    logic [31:0] preAddr;
    bit oldEn, stepEff, last;
    frameStart = fs; pixelStep = ps; regWrEn = we; regAddr = wa; regWrData = wd;
    preAddr = fetchAddr;
    oldEn = mEn;
    @(posedge clk); #2;
    frameStart = 0; pixelStep = 0; regWrEn = 0;
    stepEff = ps && mActive && oldEn && !fs;
    last = mRotF ? (mRow == 0 && mCol == 0) : (mRow == V-1 && mCol == H-1);
    mDone = stepEff && last;
    if (fs && oldEn) begin
      mActive = 1; mRotF = mRot;
      mRow = mRot ? V-1 : 0; mCol = mRot ? H-1 : 0;
    end else if (!oldEn) begin
      mActive = 0;
    end else if (stepEff) begin
      mPix = memWord(preAddr)[23:0];
      if (last) mActive = 0;
      else if (mRotF) begin
        if (mCol == 0) begin mCol = H-1; mRow--; end else mCol--;
      end else begin
        if (mCol == H-1) begin mCol = 0; mRow++; end else mCol++;
      end
    end
    if (stepEff && !fs) mPix = memWord(preAddr)[23:0];
    if (we) begin
      if (wa) begin mEn = wd[0]; mRot = wd[1]; end
      else mBase = wd[31:21];
    end
    checkOutputs();
  endtask

  task automatic runFrame(input bit flipMid);
    int guard = 0;
    cyc(1, 0, 0, 0, 0);
    while (mActive && guard < 2000) begin
      guard++;
      if (flipMid && guard == 9) // R7: rotate changes mid-frame, order must not
        cyc(0, ($urandom % 10) < 7, 1, 1, {30'd0, ~mRot, 1'b1});
      else
        cyc(0, ($urandom % 10) < 7, 0, 0, 0);
    end
    check(mDone && frameDone, "R8 done pulse at end", 32'(frameDone), 1);
    cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; regWrEn = 0; regAddr = 0; regWrData = 0; frameStart = 0; pixelStep = 0;
    mBase = 0; mEn = 0; mRot = 0; mActive = 0; mRotF = 0; mDone = 0;
    mRow = 0; mCol = 0; mPix = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R1 reset state
    regAddr = 0; #1 check(regRdData == 0, "R1 base reads zero", regRdData, 0);
    regAddr = 1; #1 check(regRdData == 0, "R1 ctrl reads zero", regRdData, 0);
    check(!fetchValid && !frameDone && {pixR, pixG, pixB} == 0, "R1 outputs idle",
          {fetchValid, frameDone, pixR, pixG, pixB}, 0);
    @(posedge clk); #2;

    // R2 base register keeps top bits only
    cyc(0, 0, 1, 0, 32'hFFFF_FFFF);
    regAddr = 0; #1 check(regRdData == 32'hFFE0_0000, "R2 base readback", regRdData, 32'hFFE0_0000);
    cyc(0, 0, 1, 0, 32'h1234_5678 ^ $urandom);
    regAddr = 0; #1 check(regRdData == {mBase, 21'd0}, "R2 base readback", regRdData, {mBase, 21'd0});

    // R3 control register fields
    cyc(0, 0, 1, 1, 32'hFFFF_FFFF);
    regAddr = 1; #1 check(regRdData == 32'h3, "R3 ctrl readback", regRdData, 3);
    cyc(0, 0, 1, 1, 32'h0);
    regAddr = 1; #1 check(regRdData == 32'h0, "R3 write zero clears", regRdData, 0);

    // R10 frameStart ignored while disabled
    cyc(1, 0, 0, 0, 0);
    check(!fetchValid, "R10 start while disabled", 32'(fetchValid), 0);

    // R5 normal frames, R6 rotated frames, R7 mid-frame rotate flip
    cyc(0, 0, 1, 1, 32'h1);
    runFrame(0);
    // R11 steps while idle
    begin
      logic [23:0] held;
      held = {pixR, pixG, pixB};
      repeat (3) cyc(0, 1, 0, 0, 0);
      check({pixR, pixG, pixB} == held, "R11 rgb unchanged when idle",
            32'({pixR, pixG, pixB}), 32'(held));
      check(!frameDone && !fetchValid, "R11 no done when idle", 32'({frameDone, fetchValid}), 0);
    end
    runFrame(1);
    cyc(0, 0, 1, 1, 32'h3);
    runFrame(0);
    check(mRotF == 1, "R6 rotated frame ran", 32'(mRotF), 1);
    runFrame(1);
    cyc(0, 0, 1, 0, $urandom);
    cyc(0, 0, 1, 1, 32'h1);
    runFrame(0);

    // R8 restart mid-frame
    cyc(1, 0, 0, 0, 0);
    repeat (6) cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    check(fetchAddr == {mBase, 21'd0}, "R8 restart at origin", fetchAddr, {mBase, 21'd0});

    // R10 disable mid-frame, re-enable resumes nothing
    repeat (4) cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 1, 32'h0);
    check(!fetchValid && {pixR, pixG, pixB} == 0, "R10 disabled outputs black",
          32'({fetchValid, pixR, pixG, pixB}), 0);
    cyc(0, 0, 1, 1, 32'h1);
    cyc(0, 1, 0, 0, 0);
    check(!fetchValid, "R10 no resume without start", 32'(fetchValid), 0);
    runFrame(0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule